// File: doc/BRIEF.md
# Bit-Manipulation Two-Operand ALU

This unit takes two 64-bit operands, an operation code and a shift-amount source, and gives one 64-bit result. It covers single-bit set, clear, invert and extract; full-width and 32-bit word rotates in both directions; the logic operations that invert the second operand; signed and unsigned minimum and maximum; scaled address adds, with forms that zero-extend the low word of the first operand; and a left shift of a zero-extended word. The result is computed combinationally and captured in an output register, so it appears one clock after the inputs.

The shift amount comes from one of two sources. When `use_imm` is high it is the separate 6-bit `imm_amt` input. When `use_imm` is low it is the low six bits of `op_b`. The word rotates use only the low five bits of whichever source is selected. The unit does no decoding, trap detection or forwarding. A surrounding execute stage presents the operation code and operands, and takes `result` one cycle later.

Top module: `bitmanip_alu`

## Requirements
- R1: `result` is a register. It reads zero on the clock edge after `rst` is sampled high. Otherwise it holds the value for the inputs sampled at the previous rising edge.
- R2: Codes 0, 1 and 2 (set, clear, invert) build a mask with only bit `s` set, where `s` is the selected amount in 0..63. Code 0 returns `op_a | mask`, code 1 returns `op_a & ~mask` and code 2 returns `op_a ^ mask`.
- R3: Code 3 (extract) returns bit `s` of `op_a` in result bit 0. All other result bits are zero.
- R4: Code 4 rotates `op_a` left by `s`. Code 5 rotates it right by `s`. Both rotate over all 64 bits.
- R5: Codes 6 (rotate left) and 7 (rotate right) rotate `op_a[31:0]` within 32 bits by `s[4:0]`. Bit 31 of the rotated word is copied into result bits 63:32.
- R6: Code 8 returns `op_a & ~op_b`, code 9 returns `op_a | ~op_b` and code 10 returns `~(op_a ^ op_b)`.
- R7: Code 11 returns the smaller and code 12 the larger of the two operands, both read as two's-complement values.
- R8: Code 13 returns the smaller and code 14 the larger of the two operands, both read as unsigned values.
- R9: Codes 15, 16 and 17 return `(op_a << k) + op_b` modulo 2^64, with k = 1, 2 and 3 respectively.
- R10: Codes 18 to 21 zero-extend `op_a[31:0]`, shift it left by k = 0, 1, 2 and 3 respectively, and add `op_b` modulo 2^64.
- R11: Code 22 zero-extends `op_a[31:0]` and shifts it left by `s`. Bits moved beyond bit 63 are lost.
- R12: When `use_imm` is 1, `s` is `imm_amt`. When `use_imm` is 0, `s` is `op_b[5:0]`. Bits 63:6 of `op_b` never affect the amount.
- R13: Codes 23 to 31 are unassigned and return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 64 | First operand (data being shifted, rotated or tested) |
| op_b | input | 64 | Second operand, and the register shift amount in bits 5:0 |
| op_sel | input | 5 | Operation code, values as listed in the requirements |
| use_imm | input | 1 | Selects `imm_amt` as the shift amount when high |
| imm_amt | input | 6 | Immediate shift amount |
| result | output | 64 | Registered result |

## Verification
The only state is the output register, so any fault shows at `result` on the first edge after the inputs are presented, and is never hidden by later cycles. A wrong amount path would show as a mask, rotate or extract off by some power of two, or as high bits of `op_b` changing the outcome. A wrong width in the word path would show as upper result bits that do not copy bit 31. Signed and unsigned compare faults show only when the operands differ in sign, so the corner vectors pair a negative value with a positive one. Carries out of bit 63 in the scaled adds test that the sum wraps.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_BSET     = 5'd0,
    OP_BCLR     = 5'd1,
    OP_BINV     = 5'd2,
    OP_BEXT     = 5'd3,
    OP_ROL      = 5'd4,
    OP_ROR      = 5'd5,
    OP_ROLW     = 5'd6,
    OP_RORW     = 5'd7,
    OP_ANDN     = 5'd8,
    OP_ORN      = 5'd9,
    OP_XNOR     = 5'd10,
    OP_MIN      = 5'd11,
    OP_MAX      = 5'd12,
    OP_MINU     = 5'd13,
    OP_MAXU     = 5'd14,
    OP_SH1ADD   = 5'd15,
    OP_SH2ADD   = 5'd16,
    OP_SH3ADD   = 5'd17,
    OP_ADDUW    = 5'd18,
    OP_SH1ADDUW = 5'd19,
    OP_SH2ADDUW = 5'd20,
    OP_SH3ADDUW = 5'd21,
    OP_SLLIUW   = 5'd22
  } bmu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 5'd22;
endpackage

// File: rtl/bmu_bitops.sv
module bmu_bitops #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] set_o,
  output logic [XLEN-1:0] clr_o,
  output logic [XLEN-1:0] inv_o,
  output logic [XLEN-1:0] ext_o
);
  logic [XLEN-1:0] onehot;

  assign onehot = {{(XLEN-1){1'b0}}, 1'b1} << amt;
  assign set_o  = a | onehot;
  assign clr_o  = a & ~onehot;
  assign inv_o  = a ^ onehot;
  assign ext_o  = {{(XLEN-1){1'b0}}, a[amt]};
endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  d,
  input  logic [SW-1:0] s,
  output logic [W-1:0]  rol_o,
  output logic [W-1:0]  ror_o
);
  // A shift by W yields zero, so s == 0 needs no special case.
  assign rol_o = (d << s) | (d >> (W - int'(s)));
  assign ror_o = (d >> s) | (d << (W - int'(s)));
endmodule

// File: rtl/bmu_logcmp.sv
module bmu_logcmp #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] andn_o,
  output logic [XLEN-1:0] orn_o,
  output logic [XLEN-1:0] xnor_o,
  output logic [XLEN-1:0] smin_o,
  output logic [XLEN-1:0] smax_o,
  output logic [XLEN-1:0] umin_o,
  output logic [XLEN-1:0] umax_o
);
  logic s_lt, u_lt;

  assign andn_o = a & ~b;
  assign orn_o  = a | ~b;
  assign xnor_o = ~(a ^ b);

  assign u_lt   = a < b;
  // Signed order flips the unsigned order only when the sign bits differ.
  assign s_lt   = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : u_lt;

  assign smin_o = s_lt ? a : b;
  assign smax_o = s_lt ? b : a;
  assign umin_o = u_lt ? a : b;
  assign umax_o = u_lt ? b : a;
endmodule

// File: rtl/bmu_shadd.sv
module bmu_shadd #(
  parameter int XLEN  = 64,
  parameter int NSCL  = 4,
  localparam int HALF = XLEN / 2,
  localparam int KW   = $clog2(NSCL)
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [KW-1:0]   k,
  input  logic            uw,
  output logic [XLEN-1:0] sum_o
);
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] cand [NSCL];

  assign src = uw ? {{HALF{1'b0}}, a[HALF-1:0]} : a;

  for (genvar g = 0; g < NSCL; g++) begin : g_scale
    assign cand[g] = (src << g) + b;
  end

  assign sum_o = cand[k];
endmodule

// File: rtl/bitmanip_alu.sv
module bitmanip_alu
  import bmu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW  = $clog2(XLEN),
  localparam int HALF = XLEN / 2,
  localparam int WSW  = $clog2(HALF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [OP_W-1:0]   op_sel,
  input  logic              use_imm,
  input  logic [SHW-1:0]    imm_amt,
  output logic [XLEN-1:0]   result
);
  bmu_op_e         op;
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] set_v, clr_v, inv_v, ext_v;
  logic [XLEN-1:0] rol_v, ror_v;
  logic [HALF-1:0] rolw_v, rorw_v;
  logic [XLEN-1:0] andn_v, orn_v, xnor_v, smin_v, smax_v, umin_v, umax_v;
  logic [XLEN-1:0] sum_v, slliuw_v;
  logic [1:0]      scl_k;
  logic            scl_uw;
  logic [XLEN-1:0] nxt;

  assign op  = bmu_op_e'(op_sel);
  assign amt = use_imm ? imm_amt : op_b[SHW-1:0];

  bmu_bitops #(.XLEN(XLEN)) u_bits (
    .a(op_a), .amt(amt),
    .set_o(set_v), .clr_o(clr_v), .inv_o(inv_v), .ext_o(ext_v)
  );

  bmu_rotate #(.W(XLEN)) u_rot_full (
    .d(op_a), .s(amt), .rol_o(rol_v), .ror_o(ror_v)
  );

  bmu_rotate #(.W(HALF)) u_rot_word (
    .d(op_a[HALF-1:0]), .s(amt[WSW-1:0]), .rol_o(rolw_v), .ror_o(rorw_v)
  );

  bmu_logcmp #(.XLEN(XLEN)) u_logcmp (
    .a(op_a), .b(op_b),
    .andn_o(andn_v), .orn_o(orn_v), .xnor_o(xnor_v),
    .smin_o(smin_v), .smax_o(smax_v), .umin_o(umin_v), .umax_o(umax_v)
  );

  always_comb begin
    scl_k  = 2'd0;
    scl_uw = 1'b0;
    case (op)
      OP_SH1ADD:   scl_k = 2'd1;
      OP_SH2ADD:   scl_k = 2'd2;
      OP_SH3ADD:   scl_k = 2'd3;
      OP_ADDUW:    scl_uw = 1'b1;
      OP_SH1ADDUW: begin scl_k = 2'd1; scl_uw = 1'b1; end
      OP_SH2ADDUW: begin scl_k = 2'd2; scl_uw = 1'b1; end
      OP_SH3ADDUW: begin scl_k = 2'd3; scl_uw = 1'b1; end
      default:     ;
    endcase
  end

  bmu_shadd #(.XLEN(XLEN), .NSCL(4)) u_shadd (
    .a(op_a), .b(op_b), .k(scl_k), .uw(scl_uw), .sum_o(sum_v)
  );

  assign slliuw_v = {{HALF{1'b0}}, op_a[HALF-1:0]} << amt;

  always_comb begin
    case (op)
      OP_BSET:     nxt = set_v;
      OP_BCLR:     nxt = clr_v;
      OP_BINV:     nxt = inv_v;
      OP_BEXT:     nxt = ext_v;
      OP_ROL:      nxt = rol_v;
      OP_ROR:      nxt = ror_v;
      OP_ROLW:     nxt = {{HALF{rolw_v[HALF-1]}}, rolw_v};
      OP_RORW:     nxt = {{HALF{rorw_v[HALF-1]}}, rorw_v};
      OP_ANDN:     nxt = andn_v;
      OP_ORN:      nxt = orn_v;
      OP_XNOR:     nxt = xnor_v;
      OP_MIN:      nxt = smin_v;
      OP_MAX:      nxt = smax_v;
      OP_MINU:     nxt = umin_v;
      OP_MAXU:     nxt = umax_v;
      OP_SH1ADD, OP_SH2ADD, OP_SH3ADD,
      OP_ADDUW, OP_SH1ADDUW, OP_SH2ADDUW, OP_SH3ADDUW:
                   nxt = sum_v;
      OP_SLLIUW:   nxt = slliuw_v;
      default:     nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= nxt;
  end
endmodule

// File: rtl/bitmanip_alu_chk.sv
module bitmanip_alu_chk
  import bmu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW  = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [OP_W-1:0] op_sel,
  input logic            use_imm,
  input logic [SHW-1:0]  imm_amt,
  input logic [XLEN-1:0] result
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result == '0));

  p_one_bit_flip_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_BINV) |=> ($countones(result ^ $past(op_a)) == 1));

  p_at_most_one_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_BSET || op_sel == OP_BCLR) |=> ($countones(result ^ $past(op_a)) <= 1));

  p_extract_lsb_only_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_BEXT) |=> (result[XLEN-1:1] == '0));

  p_word_sign_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ROLW || op_sel == OP_RORW)
      |=> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));

  p_andn_disjoint_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ANDN) |=> (((result & $past(op_b)) == '0) && ((result & ~$past(op_a)) == '0)));

  p_smax_pick_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_MAX) |=> ((result == $past(op_a) || result == $past(op_b))
      && ($signed(result) >= $signed($past(op_a))) && ($signed(result) >= $signed($past(op_b)))));

  p_umin_pick_r8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_MINU) |=> ((result == $past(op_a) || result == $past(op_b))
      && (result <= $past(op_a)) && (result <= $past(op_b))));

  p_imm_bit_set_r12: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_BSET && use_imm) |=> (result[$past(imm_amt)] == 1'b1));

  p_unassigned_zero_r13: assert property (@(posedge clk) disable iff (rst)
    (op_sel > OP_LAST) |=> (result == '0));
endmodule

bind bitmanip_alu bitmanip_alu_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
  .use_imm(use_imm), .imm_amt(imm_amt), .result(result)
);

// File: tb/bitmanip_alu_bench.sv
`timescale 1ns/1ps
module bitmanip_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [4:0]  op_sel = '0;
  logic        use_imm = 1'b0;
  logic [5:0]  imm_amt = '0;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitmanip_alu #(.XLEN(64)) u_bitmanip_alu (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .use_imm(use_imm), .imm_amt(imm_amt), .result(result)
  );

  function automatic logic [63:0] ref_res(input int op, input logic [63:0] a,
                                          input logic [63:0] b, input bit ui,
                                          input logic [5:0] imm);
    int s, sw;
    logic [63:0] r;
    logic [31:0] w;
    s  = ui ? int'(imm) : int'(b[5:0]);
    sw = s % 32;
    r  = '0;
    w  = '0;
    case (op)
      0: r = a | (64'd1 << s);
      1: r = a & ~(64'd1 << s);
      2: r = a ^ (64'd1 << s);
      3: r[0] = a[s];
      4: for (int i = 0; i < 64; i++) r[(i + s) % 64] = a[i];
      5: for (int i = 0; i < 64; i++) r[i] = a[(i + s) % 64];
      6: begin
           for (int i = 0; i < 32; i++) w[(i + sw) % 32] = a[i];
           r = {{32{w[31]}}, w};
         end
      7: begin
           for (int i = 0; i < 32; i++) w[i] = a[(i + sw) % 32];
           r = {{32{w[31]}}, w};
         end
      8:  r = a & ~b;
      9:  r = a | ~b;
      10: r = ~(a ^ b);
      11: r = ($signed(a) < $signed(b)) ? a : b;
      12: r = ($signed(a) > $signed(b)) ? a : b;
      13: r = (a < b) ? a : b;
      14: r = (a > b) ? a : b;
      15, 16, 17: r = (a << (op - 14)) + b;
      18, 19, 20, 21: r = ({32'd0, a[31:0]} << (op - 18)) + b;
      22: r = {32'd0, a[31:0]} << s;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_tag(input int op);
    if (op <= 2)  return "R2";
    if (op == 3)  return "R3";
    if (op <= 5)  return "R4";
    if (op <= 7)  return "R5";
    if (op <= 10) return "R6";
    if (op <= 12) return "R7";
    if (op <= 14) return "R8";
    if (op <= 17) return "R9";
    if (op <= 21) return "R10";
    if (op == 22) return "R11";
    return "R13";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: result=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs are driven at a falling edge; the rising edge registers the
  // result and the next falling edge samples it.
  task automatic run(input int op, input logic [63:0] a, input logic [63:0] b,
                     input bit ui, input logic [5:0] imm, input string tag);
    op_sel  = op[4:0];
    op_a    = a;
    op_b    = b;
    use_imm = ui;
    imm_amt = imm;
    @(negedge clk);
    check(tag, result, ref_res(op, a, b, ui, imm));
  endtask

  initial begin
    // R1: reset holds zero even with an all-ones operation presented
    op_sel = 5'd10;
    repeat (3) @(negedge clk);
    check("R1", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", result, 64'hFFFF_FFFF_FFFF_FFFF);
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, 64'd0);
    rst = 1'b0;

    // R2 masks at both ends
    run(0, 64'd0, 64'd63, 1'b0, 6'd0, "R2");
    run(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 6'd0, "R2");
    run(2, 64'h8000_0000_0000_0000, 64'd0, 1'b1, 6'd63, "R2");
    // R3 top bit and a clear bit
    run(3, 64'h8000_0000_0000_0000, 64'd63, 1'b0, 6'd0, "R3");
    run(3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 6'd63, "R3");
    // R4 zero and maximum amounts
    run(4, 64'h0123_4567_89AB_CDEF, 64'd0, 1'b0, 6'd0, "R4");
    run(5, 64'h0123_4567_89AB_CDEF, 64'd0, 1'b1, 6'd63, "R4");
    // R5: amount 33 acts as 1; bit 31 set spreads to the top half
    run(6, 64'hFFFF_0000_4000_0000, 64'd33, 1'b0, 6'd0, "R5");
    run(7, 64'h0000_0000_0000_0001, 64'd0, 1'b1, 6'd1, "R5");
    // R6
    run(8, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 1'b0, 6'd0, "R6");
    run(9, 64'd0, 64'h0000_0000_FFFF_FFFF, 1'b0, 6'd0, "R6");
    // R7/R8: negative versus positive splits the two orders
    run(11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 6'd0, "R7");
    run(12, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 6'd0, "R7");
    run(13, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 6'd0, "R8");
    run(14, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 6'd0, "R8");
    // R9 wrap past bit 63
    run(17, 64'hF000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'd0, "R9");
    // R10 high half of op_a discarded
    run(18, 64'hFFFF_FFFF_8000_0000, 64'd5, 1'b0, 6'd0, "R10");
    run(21, 64'hDEAD_BEEF_FFFF_FFFF, 64'd1, 1'b0, 6'd0, "R10");
    // R11 bits shifted past 63 lost
    run(22, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 6'd40, "R11");
    // R12 upper op_b bits ignored; immediate overrides op_b
    run(0, 64'd0, 64'hFFFF_FFFF_FFFF_FFC5, 1'b0, 6'd0, "R12");
    run(0, 64'd0, 64'd7, 1'b1, 6'd12, "R12");
    run(5, 64'h1, 64'hAAAA_AAAA_AAAA_AA80, 1'b0, 6'd9, "R12");
    // R13
    run(31, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd5, "R13");
    run(23, 64'h1234, 64'h5678, 1'b0, 6'd0, "R13");

    // Constrained random, fixed seed
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [63:0] ra, rb;
      op = (($urandom % 8) == 0) ? int'($urandom % 32) : int'($urandom % 23);
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (($urandom % 4) == 0) rb[63] = ra[63];
      run(op, ra, rb, bit'($urandom % 2), 6'($urandom), op_tag(op));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule